// File: doc/BRIEF.md
# Peripheral Idle Timer Bank

This block watches decoded bus traffic and reports to power-management firmware when a group of peripherals has gone quiet. It holds six independent countdown timers. One watches the parallel and serial ports, one watches keyboard and mouse traffic, three watch programmable user device windows, and one watches a hard disk data port. Each timer counts down by one on every pulse of a shared one-second strobe. Any access that lands in a timer's monitored space reloads that timer with its programmed count.

When a timer reaches zero it sets a sticky per-timer status bit. The block then raises a system management interrupt request, which stays high while any status bit is set. A summary bit that is the OR of all per-timer bits is also exposed. Firmware programs the counts, the enables, the routing options and the user windows through a small register port, and clears status by writing ones.

Timer index used throughout: 0 ports, 1 keyboard/mouse, 2 to 4 user devices 0 to 2, 5 disk.

Top module: `idle_watch_bank`

## Requirements
- R1: After reset every count register reads 0, every status bit is 0, and `smi_req` is 0.
- R2: Count registers live at register addresses 0 to 5, one per timer index, and read back their written value. A write also loads the value into the live counter at once, so a value N with the timer enabled expires on the Nth following tick.
- R3: A counter decrements only in a cycle where `tick_1s` is high and its timer is enabled. A disabled timer neither counts nor expires.
- R4: When an enabled counter steps from 1 to 0, the timer's status bit is set and `smi_req` goes high. The counter then stays at zero, and no further expiry occurs until it is reloaded.
- R5: I/O accesses to 278h-27Fh, 378h-37Fh, 2F8h-2FFh or 3F8h-3FFh reload timer 0. Memory accesses at those addresses reload nothing.
- R6: I/O accesses to 060h or 064h reload timer 1. Routing register 11 bit 0 enables the mouse-on-serial option, and bit 1 selects which serial range it applies to (0 = 3F8h range, 1 = 2F8h range). With the option enabled, the selected range reloads timer 1 instead of timer 0, and the other serial range still reloads timer 0.
- R7: Timer 5 reloads only on an I/O access to exactly 1F0h when register 11 bit 2 is 0, or to exactly 170h when that bit is 1.
- R8: User device k (k = 0 to 2) reloads timer 2+k when the access address matches register 12+k in all bits above bit 3 (a 16-byte aligned window), and the access space matches register 15 bit k (1 = memory, 0 = I/O).
- R9: Register 6 bits 2 to 6 enable timers 0 to 4. Register 7 bit 7 enables timer 5.
- R10: Register 8 bits 2 to 6 show the status of timers 0 to 4, and register 9 bit 4 shows timer 5. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Register 10 bit 0 and `status_top` are the OR of all status bits. `smi_req` is high while any status bit is set.
- R11: A timer loaded with a count of 0 stays idle and never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| acc_vld | input | 1 | one-cycle strobe for a decoded bus access |
| acc_mem | input | 1 | 1 = memory space access, 0 = I/O space access |
| acc_addr | input | 16 | access address |
| tick_1s | input | 1 | one-second timebase strobe |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe, data returned on the next cycle |
| reg_addr | input | 4 | register address |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | registered read data |
| status_lvl2 | output | 6 | per-timer sticky status, bit = timer index |
| status_top | output | 1 | OR of all per-timer status bits |
| smi_req | output | 1 | system management interrupt request |

## Verification
A vector table loads every timer with a count of two and spends one tick. It then presents a single access and spends a second tick. The status pattern that results shows exactly which timers the access reloaded. The vectors cover each fixed port range and the keyboard ports, with the mouse option off, on for either serial range, and on for the other range. They also cover both disk port choices and addresses one past a port, user windows at their edges and in the wrong space, and fixed ports hit in memory space. Each of these separates a correct decode from one that routes traffic to the wrong timer or misses it. Directed tests follow. They cover counting without ticks, disabled timers, zero counts, the expiry step after a count write, fire-once behaviour, and write-one-to-clear of one bit while another stays set.

// File: rtl/idle_watch_pkg.sv
package idle_watch_pkg;
  localparam int NUM_TMR  = 6;
  localparam int NUM_USR  = 3;
  localparam int DATA_W   = 16;
  localparam int REG_AW   = 4;

  // timer indices
  localparam int T_PORTS  = 0;
  localparam int T_INPUT  = 1;
  localparam int T_USR0   = 2;
  localparam int T_DISK   = 5;

  // register addresses
  localparam logic [REG_AW-1:0] RA_EN_A   = 4'd6;
  localparam logic [REG_AW-1:0] RA_EN_B   = 4'd7;
  localparam logic [REG_AW-1:0] RA_ST_A   = 4'd8;
  localparam logic [REG_AW-1:0] RA_ST_B   = 4'd9;
  localparam logic [REG_AW-1:0] RA_TOP    = 4'd10;
  localparam logic [REG_AW-1:0] RA_ROUTE  = 4'd11;
  localparam logic [REG_AW-1:0] RA_UBASE0 = 4'd12;
  localparam logic [REG_AW-1:0] RA_UCTL   = 4'd15;

  // bit positions with behavioural meaning
  localparam int EN_A_LSB  = 2;
  localparam int EN_B_BIT  = 7;
  localparam int ST_B_BIT  = 4;
endpackage

// File: rtl/idle_hit_decode.sv
module idle_hit_decode #(
  parameter int ADDR_W    = 16,
  parameter int NUSR      = 3,
  parameter int BASE_W    = 16,
  parameter int WIN_SHIFT = 4
) (
  input  logic                       acc_vld,
  input  logic                       acc_mem,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic                       mouse_en,
  input  logic                       mouse_sel,
  input  logic                       disk_sel,
  input  logic [NUSR-1:0][BASE_W-1:0] usr_base,
  input  logic [NUSR-1:0]            usr_mem,
  output logic [NUSR+2:0]            hit
);
  localparam int NHIT = NUSR + 3;

  function automatic logic blk8(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:3] == b[ADDR_W-1:3];
  endfunction

  logic io_acc;
  logic lpt_hit, ser_a, ser_b, kbd_hit, ser_a_mouse, ser_b_mouse;
  logic [ADDR_W-1:0] disk_port;

  assign io_acc      = acc_vld && !acc_mem;
  assign lpt_hit     = blk8(acc_addr, ADDR_W'(16'h0378)) || blk8(acc_addr, ADDR_W'(16'h0278));
  assign ser_a       = blk8(acc_addr, ADDR_W'(16'h03F8));
  assign ser_b       = blk8(acc_addr, ADDR_W'(16'h02F8));
  assign ser_a_mouse = mouse_en && !mouse_sel;
  assign ser_b_mouse = mouse_en &&  mouse_sel;
  assign kbd_hit     = (acc_addr == ADDR_W'(16'h0060)) || (acc_addr == ADDR_W'(16'h0064));
  assign disk_port   = disk_sel ? ADDR_W'(16'h0170) : ADDR_W'(16'h01F0);

  assign hit[0] = io_acc && (lpt_hit || (ser_a && !ser_a_mouse) || (ser_b && !ser_b_mouse));
  assign hit[1] = io_acc && (kbd_hit || (ser_a && ser_a_mouse) || (ser_b && ser_b_mouse));
  assign hit[NHIT-1] = io_acc && (acc_addr == disk_port);

  for (genvar k = 0; k < NUSR; k++) begin : g_usr
    logic [ADDR_W-1:0] base_ext;
    assign base_ext = ADDR_W'(usr_base[k]);
    assign hit[2+k] = acc_vld && (acc_mem == usr_mem[k]) &&
                      (acc_addr[ADDR_W-1:WIN_SHIFT] == base_ext[ADDR_W-1:WIN_SHIFT]);
  end
endmodule

// File: rtl/idle_countdown.sv
module idle_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_hit,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expire
);
  logic [CNT_W-1:0] ctr;
  logic             step;

  assign step   = en && tick && !load_wr && !reload_hit && (ctr != '0);
  assign expire = step && (ctr == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)             ctr <= '0;
    else if (load_wr)    ctr <= load_val;
    else if (reload_hit) ctr <= reload_val;
    else if (step)       ctr <= ctr - CNT_W'(1);
  end

  // R3: without an enabled tick, a reload or a write, the counter holds
  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_wr && !reload_hit && !(en && tick)) |=> $stable(ctr));

  // R4 / R11: an exhausted counter stays at zero until it is reloaded
  assert_idle_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (ctr == '0 && !load_wr && !reload_hit) |=> (ctr == '0 && !expire));

  // R2: a register write lands in the live counter on the next edge
  assert_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> (ctr == $past(load_val)));
endmodule

// File: rtl/idle_status_regs.sv
module idle_status_regs #(
  parameter int NUM = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] fire,
  input  logic [NUM-1:0] clr,
  output logic [NUM-1:0] stat,
  output logic           top,
  output logic           smi
);
  logic [NUM-1:0] stat_nxt;

  // a new expiry wins over a clear in the same cycle
  assign stat_nxt = (stat & ~clr) | fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      top  <= 1'b0;
      smi  <= 1'b0;
    end else begin
      stat <= stat_nxt;
      top  <= |stat_nxt;
      smi  <= |stat_nxt;
    end
  end

  // R4: an expiry always leaves the interrupt request raised
  assert_fire_raises_smi_R4: assert property (@(posedge clk) disable iff (rst)
    (|fire) |=> smi);

  // R10: the request only drops after a write-one-to-clear
  assert_smi_drop_needs_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(smi) |-> $past(|clr));

  // R10: sticky bits never clear on their own
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (clr == '0) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/idle_watch_bank.sv
module idle_watch_bank
  import idle_watch_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_vld,
  input  logic              acc_mem,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              tick_1s,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_TMR-1:0] status_lvl2,
  output logic              status_top,
  output logic              smi_req
);
  localparam int NEN_A = NUM_TMR - 1;

  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_q;
  logic [NEN_A-1:0]               en_a_q;
  logic                           en_b_q;
  logic [2:0]                     route_q;
  logic [NUM_USR-1:0][DATA_W-1:0] ubase_q;
  logic [NUM_USR-1:0]             umem_q;

  logic [NUM_TMR-1:0] hit, fire, clr, tmr_en, cnt_wr;
  logic [NUM_TMR-1:0] stat;
  logic               top;
  logic [DATA_W-1:0]  rd_mux;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_a_q  <= '0;
      en_b_q  <= 1'b0;
      route_q <= '0;
      umem_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_EN_A:  en_a_q  <= reg_wdata[EN_A_LSB +: NEN_A];
        RA_EN_B:  en_b_q  <= reg_wdata[EN_B_BIT];
        RA_ROUTE: route_q <= reg_wdata[2:0];
        RA_UCTL:  umem_q  <= reg_wdata[NUM_USR-1:0];
        default: ;
      endcase
    end
  end

  for (genvar u = 0; u < NUM_USR; u++) begin : g_ubase
    always_ff @(posedge clk) begin
      if (rst) ubase_q[u] <= '0;
      else if (reg_wr && reg_addr == RA_UBASE0 + REG_AW'(u)) ubase_q[u] <= reg_wdata;
    end
  end

  idle_hit_decode #(
    .ADDR_W(ADDR_W), .NUSR(NUM_USR), .BASE_W(DATA_W), .WIN_SHIFT(WIN_SHIFT)
  ) u_dec (
    .acc_vld  (acc_vld),
    .acc_mem  (acc_mem),
    .acc_addr (acc_addr),
    .mouse_en (route_q[0]),
    .mouse_sel(route_q[1]),
    .disk_sel (route_q[2]),
    .usr_base (ubase_q),
    .usr_mem  (umem_q),
    .hit      (hit)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign cnt_wr[t] = reg_wr && (reg_addr == REG_AW'(t));

    always_ff @(posedge clk) begin
      if (rst)            cnt_q[t] <= '0;
      else if (cnt_wr[t]) cnt_q[t] <= reg_wdata;
    end

    if (t < NEN_A) begin : g_en_a
      assign tmr_en[t] = en_a_q[t];
      assign clr[t]    = reg_wr && (reg_addr == RA_ST_A) && reg_wdata[EN_A_LSB + t];
    end else begin : g_en_b
      assign tmr_en[t] = en_b_q;
      assign clr[t]    = reg_wr && (reg_addr == RA_ST_B) && reg_wdata[ST_B_BIT];
    end

    idle_countdown #(.CNT_W(DATA_W)) u_cd (
      .clk       (clk),
      .rst       (rst),
      .en        (tmr_en[t]),
      .tick      (tick_1s),
      .load_wr   (cnt_wr[t]),
      .load_val  (reg_wdata),
      .reload_hit(hit[t]),
      .reload_val(cnt_q[t]),
      .expire    (fire[t])
    );
  end

  idle_status_regs #(.NUM(NUM_TMR)) u_st (
    .clk (clk),
    .rst (rst),
    .fire(fire),
    .clr (clr),
    .stat(stat),
    .top (top),
    .smi (smi_req)
  );

  assign status_lvl2 = stat;
  assign status_top  = top;

  always_comb begin
    rd_mux = '0;
    if (reg_addr < REG_AW'(NUM_TMR)) rd_mux = cnt_q[reg_addr[2:0]];
    else begin
      case (reg_addr)
        RA_EN_A:  rd_mux[EN_A_LSB +: NEN_A] = en_a_q;
        RA_EN_B:  rd_mux[EN_B_BIT]          = en_b_q;
        RA_ST_A:  rd_mux[EN_A_LSB +: NEN_A] = stat[NEN_A-1:0];
        RA_ST_B:  rd_mux[ST_B_BIT]          = stat[NUM_TMR-1];
        RA_TOP:   rd_mux[0]                 = top;
        RA_ROUTE: rd_mux[2:0]               = route_q;
        RA_UCTL:  rd_mux[NUM_USR-1:0]       = umem_q;
        default:  rd_mux = ubase_q[2'(reg_addr - RA_UBASE0)];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R10: the summary bit tracks the per-timer bits
  assert_top_is_or_R10: assert property (@(posedge clk) disable iff (rst)
    status_top == (|status_lvl2));

  // R1: nothing is pending in the first cycle after reset
  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(rst) |-> (status_lvl2 == '0 && !smi_req));
endmodule

// File: tb/idle_watch_bank_tb_top.sv
module idle_watch_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_vld = 1'b0, acc_mem = 1'b0, tick_1s = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [5:0]  status_lvl2;
  logic        status_top, smi_req;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  idle_watch_bank dut_i (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_mem(acc_mem), .acc_addr(acc_addr),
    .tick_1s(tick_1s), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_lvl2(status_lvl2),
    .status_top(status_top), .smi_req(smi_req)
  );

  // {route[2:0], mem, addr[15:0], expected reload mask[5:0]}
  localparam int NV = 17;
  localparam logic [25:0] VEC [0:NV-1] = '{
    {3'd0, 1'b0, 16'h0378, 6'b000001},
    {3'd0, 1'b0, 16'h027F, 6'b000001},
    {3'd0, 1'b0, 16'h03FA, 6'b000001},
    {3'd1, 1'b0, 16'h03FA, 6'b000010},
    {3'd1, 1'b0, 16'h02F8, 6'b000001},
    {3'd3, 1'b0, 16'h02FC, 6'b000010},
    {3'd0, 1'b0, 16'h0060, 6'b000010},
    {3'd0, 1'b0, 16'h0064, 6'b000010},
    {3'd0, 1'b0, 16'h01F0, 6'b100000},
    {3'd0, 1'b0, 16'h0170, 6'b000000},
    {3'd4, 1'b0, 16'h0170, 6'b100000},
    {3'd0, 1'b0, 16'h01F1, 6'b000000},
    {3'd0, 1'b0, 16'h0505, 6'b000100},
    {3'd0, 1'b1, 16'h0505, 6'b000000},
    {3'd0, 1'b1, 16'hA00F, 6'b001000},
    {3'd0, 1'b0, 16'h060F, 6'b010000},
    {3'd0, 1'b1, 16'h0378, 6'b000000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1s = 1'b1;
      @(negedge clk);
      tick_1s = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic m);
    acc_vld = 1'b1; acc_addr = a; acc_mem = m;
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  task automatic clear_all();
    wr(4'd8, 16'h007C);
    wr(4'd9, 16'h0010);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 status", {26'd0, status_lvl2}, 32'd0);
    check("R1 smi", {31'd0, smi_req}, 32'd0);
    rd(4'd3, d);
    check("R1 count reads 0", {16'd0, d}, 32'd0);

    // common setup: enables (R9), user windows (R8)
    wr(4'd6, 16'h007C);
    wr(4'd7, 16'h0080);
    wr(4'd12, 16'h0500);
    wr(4'd13, 16'hA000);
    wr(4'd14, 16'h0600);
    wr(4'd15, 16'h0002);

    // table: which timers did each access reload (R5 R6 R7 R8)
    for (int v = 0; v < NV; v++) begin
      wr(4'd11, {13'd0, VEC[v][25:23]});
      for (int t = 0; t < 6; t++) wr(4'(t), 16'd2);
      tick(1);
      access(VEC[v][21:6], VEC[v][22]);
      tick(1);
      check($sformatf("R5 R6 R7 R8 vector %0d", v), {26'd0, status_lvl2}, {26'd0, ~VEC[v][5:0]});
      check($sformatf("R4 smi vector %0d", v), {31'd0, smi_req}, 32'd1);
      clear_all();
    end
    wr(4'd11, 16'd0);

    // R11 zero counts stay idle
    for (int t = 0; t < 6; t++) wr(4'(t), 16'd0);
    clear_all();
    tick(4);
    check("R11 zero count no fire", {26'd0, status_lvl2}, 32'd0);

    // R2 readback
    wr(4'd2, 16'h1234);
    rd(4'd2, d);
    check("R2 readback", {16'd0, d}, 32'h1234);
    wr(4'd2, 16'd0);

    // R3 no tick, no count
    wr(4'd0, 16'd1);
    repeat (20) @(negedge clk);
    check("R3 no tick no fire", {26'd0, status_lvl2}, 32'd0);

    // R2 write loads live counter: count 3 expires on the 3rd tick
    wr(4'd0, 16'd3);
    tick(2);
    check("R2 not yet expired", {26'd0, status_lvl2}, 32'd0);
    tick(1);
    check("R2 expired on third tick", {26'd0, status_lvl2}, 32'h01);
    check("R4 smi raised", {31'd0, smi_req}, 32'd1);
    check("R10 top port", {31'd0, status_top}, 32'd1);
    rd(4'd8, d);
    check("R10 status reg A bit 2", {16'd0, d}, 32'h0004);
    rd(4'd10, d);
    check("R10 top reg", {16'd0, d}, 32'h0001);

    // R4 fire once
    wr(4'd8, 16'h0004);
    check("R10 cleared", {31'd0, smi_req}, 32'd0);
    tick(3);
    check("R4 no refire at zero", {26'd0, status_lvl2}, 32'd0);

    // R3 disabled timer; R9 enable bit positions
    wr(4'd6, 16'h0000);
    wr(4'd7, 16'h0000);
    wr(4'd0, 16'd1);
    wr(4'd5, 16'd1);
    tick(2);
    check("R3 disabled no fire", {26'd0, status_lvl2}, 32'd0);
    wr(4'd7, 16'h0080);
    tick(1);
    check("R9 disk enable bit 7", {26'd0, status_lvl2}, 32'h20);
    rd(4'd9, d);
    check("R10 status reg B bit 4", {16'd0, d}, 32'h0010);
    wr(4'd6, 16'h0004);
    tick(1);
    check("R9 reg A bit 2 enables timer 0", {26'd0, status_lvl2}, 32'h21);

    // R10 write-one-to-clear selectivity
    wr(4'd6, 16'h007C);
    wr(4'd1, 16'd1);
    tick(1);
    check("R4 timer 1 fired", {26'd0, status_lvl2}, 32'h23);
    wr(4'd8, 16'h0004);
    check("R10 clear only bit 2", {26'd0, status_lvl2}, 32'h22);
    wr(4'd8, 16'h0000);
    check("R10 writing zero keeps bits", {26'd0, status_lvl2}, 32'h22);
    wr(4'd9, 16'h0010);
    check("R10 disk cleared", {26'd0, status_lvl2}, 32'h02);
    check("R10 smi held by remaining bit", {31'd0, smi_req}, 32'd1);
    wr(4'd8, 16'h0008);
    check("R10 all clear smi low", {30'd0, status_top, smi_req}, 32'd0);

    finish_run();
  end
endmodule